// File: doc/BRIEF.md
# Motion Wake-Up and Back-to-Sleep Engine

This block watches a stream of signed three-axis acceleration samples and keeps a single wake/sleep state. While asleep it counts consecutive samples in which at least one enabled axis direction exceeds a wake threshold. When that count reaches a programmed length, the block moves to the awake state. While awake it counts consecutive samples in which no enabled axis direction exceeds a separate back-to-sleep threshold, and returns to sleep when that second count reaches its own length. Because the lengths are counted in sample periods, the delay in seconds is the length divided by the sample rate. For example, a length of 5 at 50 Hz gives 0.1 s.

Each transition caused by motion or stillness sets a latched event flag. The flags drive one interrupt pin whose active level is selectable. Both flags stay set until the host pulses a release input. Configuration arrives as static inputs: two thresholds, two lengths, a six-bit direction enable, two engine enables and the pin polarity. The host also has a force-sleep pulse, which drops the block back to sleep without raising an event.

The controller has two states. `ST_SLEEP` is entered at reset. It moves to `ST_AWAKE` on the transition *motion confirmed*, which happens when the wake debouncer completes. `ST_AWAKE` moves back to `ST_SLEEP` on either of two transitions: *stillness confirmed*, when the back-to-sleep debouncer completes, or *forced sleep*, when the host pulses `force_sleep`.

Top module: `motion_wake_sleep`

## Requirements
- R1: After reset, `awake`, `wake_evt` and `sleep_evt` are 0, and `irq_pin` sits at its inactive level.
- R2: In sleep with `wake_en`=1, the following applies when `wake_len` consecutive valid samples each have some enabled direction whose magnitude is strictly greater than `wake_thr`. At the clock edge that takes the last of those samples, `awake` and `wake_evt` become 1. A `wake_len` of 0 behaves as 1.
- R3: A valid sample with no enabled direction above `wake_thr` resets the wake count to zero. Cycles without `smp_valid` leave the count unchanged.
- R4: Direction enable order is as follows. `dir_mask[0]` is +X, `[1]` is -X, `[2]` is +Y, `[3]` is -Y, `[4]` is +Z and `[5]` is -Z. A bit of 1 lets that direction take part, and a bit of 0 means that direction never counts toward either engine.
- R5: In the awake state with `sleep_en`=1, the following applies when `sleep_len` consecutive valid samples have every enabled direction at or below `sleep_thr`. At the edge that takes the last of those samples, `awake` becomes 0 and `sleep_evt` becomes 1. Any valid sample with an enabled direction above `sleep_thr` resets that count. A `sleep_len` of 0 behaves as 1.
- R6: While `wake_en`=0 the wake count is held at zero and no wake occurs. While `sleep_en`=0 the same applies to the back-to-sleep count.
- R7: A `force_sleep` pulse makes `awake` 0 at the next edge and clears both counts. It sets no event flag and leaves existing flags unchanged. It overrides a wake that would complete in the same cycle.
- R8: `wake_evt` and `sleep_evt` stay set until an `irq_release` pulse, which clears both flags and returns `irq_pin` to its inactive level.
- R9: If an event occurs in the same cycle as `irq_release`, that event's flag ends up set and `irq_pin` stays active.
- R10: `irq_pin` is active when either flag is set. It is driven high when active if `irq_act_high`=1, and low when active if `irq_act_high`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | New sample present this cycle |
| smp_x | input | SW | Signed X acceleration |
| smp_y | input | SW | Signed Y acceleration |
| smp_z | input | SW | Signed Z acceleration |
| wake_en | input | 1 | Wake engine enable |
| sleep_en | input | 1 | Back-to-sleep engine enable |
| dir_mask | input | 6 | Per-direction participation enable |
| wake_thr | input | SW | Wake magnitude threshold (unsigned) |
| sleep_thr | input | SW | Back-to-sleep magnitude threshold (unsigned) |
| wake_len | input | CW | Wake length in samples |
| sleep_len | input | CW | Back-to-sleep length in samples |
| irq_act_high | input | 1 | Interrupt pin polarity select |
| force_sleep | input | 1 | Force-sleep pulse |
| irq_release | input | 1 | Interrupt release pulse |
| awake | output | 1 | Current state, 1 when awake |
| wake_evt | output | 1 | Latched wake event flag |
| sleep_evt | output | 1 | Latched back-to-sleep event flag |
| irq_pin | output | 1 | Interrupt output |

## Verification
The assertions check several rules on every cycle:
- A count collapses whenever its engine is disarmed, or when a valid sample misses.
- A count holds steady across gaps between samples.
- `awake` rises only on a valid sample while the wake engine is enabled and no force is present.
- `awake` falls only through a force or a valid sample with the back-to-sleep engine enabled.
- Flags hold until released, and a simultaneous event beats the release.

Only the bench scenarios can show the rest: the exact sample on which each transition lands, the threshold equality edge, the direction-mask bit order, zero-length handling and the two pin polarities.

// File: rtl/mws_pkg.sv
package mws_pkg;
    typedef enum logic [0:0] {
        ST_SLEEP = 1'b0,
        ST_AWAKE = 1'b1
    } mws_state_e;

    localparam int AXES = 3;
    localparam int DIRS = 2 * AXES;
endpackage

// File: rtl/mws_dir_detect.sv
module mws_dir_detect
    import mws_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic [AXES-1:0][SW-1:0] smp,
    input  logic [DIRS-1:0]         dir_en,
    input  logic [SW-1:0]           thr,
    output logic                    exceed
);
    logic [DIRS-1:0] hit;

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        logic          neg;
        logic [SW-1:0] mag;
        logic          big;
        assign neg = smp[a][SW-1];
        assign mag = neg ? (~smp[a] + 1'b1) : smp[a];
        assign big = mag > thr;
        assign hit[2*a]   = big & ~neg & dir_en[2*a];
        assign hit[2*a+1] = big &  neg & dir_en[2*a+1];
    end

    assign exceed = |hit;
endmodule

// File: rtl/mws_debounce.sv
module mws_debounce #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          step,
    input  logic          hit,
    input  logic [CW-1:0] limit,
    output logic          fire
);
    logic [CW-1:0] cnt;
    logic [CW:0]   nxt;
    logic [CW:0]   lim_eff;

    assign nxt     = {1'b0, cnt} + 1'b1;
    assign lim_eff = (limit == '0) ? (CW+1)'(1) : {1'b0, limit};
    assign fire    = arm & step & hit & (nxt >= lim_eff);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (!arm)              cnt <= '0;
        else if (step) begin
            if (!hit || fire)       cnt <= '0;
            else                    cnt <= nxt[CW-1:0];
        end
    end

    assert_disarm_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (cnt == '0));
    assert_miss_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && step && !hit) |=> (cnt == '0));
    assert_gap_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !step) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/mws_status.sv
module mws_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_wake,
    input  logic set_sleep,
    input  logic release_i,
    input  logic act_high,
    output logic wake_flag,
    output logic sleep_flag,
    output logic irq_pin
);
    logic any_flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_flag  <= 1'b0;
            sleep_flag <= 1'b0;
        end else begin
            if (set_wake)        wake_flag <= 1'b1;
            else if (release_i)  wake_flag <= 1'b0;
            if (set_sleep)       sleep_flag <= 1'b1;
            else if (release_i)  sleep_flag <= 1'b0;
        end
    end

    assign any_flag = wake_flag | sleep_flag;
    assign irq_pin  = act_high ? any_flag : ~any_flag;

    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_flag && !release_i) |=> wake_flag);
    assert_release_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i && !set_wake && !set_sleep) |=> (!wake_flag && !sleep_flag));
    assert_event_beats_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_wake || set_sleep) |=> (wake_flag || sleep_flag));
endmodule

// File: rtl/motion_wake_sleep.sv
module motion_wake_sleep
    import mws_pkg::*;
#(
    parameter int SW = 16,
    parameter int CW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [SW-1:0] smp_x,
    input  logic signed [SW-1:0] smp_y,
    input  logic signed [SW-1:0] smp_z,
    input  logic                 wake_en,
    input  logic                 sleep_en,
    input  logic [5:0]           dir_mask,
    input  logic [SW-1:0]        wake_thr,
    input  logic [SW-1:0]        sleep_thr,
    input  logic [CW-1:0]        wake_len,
    input  logic [CW-1:0]        sleep_len,
    input  logic                 irq_act_high,
    input  logic                 force_sleep,
    input  logic                 irq_release,
    output logic                 awake,
    output logic                 wake_evt,
    output logic                 sleep_evt,
    output logic                 irq_pin
);
    mws_state_e              state, state_nxt;
    logic [AXES-1:0][SW-1:0] smp_bus;
    logic                    over_wake, over_sleep;
    logic                    wake_arm, sleep_arm;
    logic                    wake_fire, sleep_fire;

    assign smp_bus = {smp_z, smp_y, smp_x};

    mws_dir_detect #(.SW(SW)) u_wake_det (
        .smp(smp_bus), .dir_en(dir_mask), .thr(wake_thr), .exceed(over_wake));
    mws_dir_detect #(.SW(SW)) u_sleep_det (
        .smp(smp_bus), .dir_en(dir_mask), .thr(sleep_thr), .exceed(over_sleep));

    assign wake_arm  = (state == ST_SLEEP) & wake_en  & ~force_sleep;
    assign sleep_arm = (state == ST_AWAKE) & sleep_en & ~force_sleep;

    mws_debounce #(.CW(CW)) u_wake_cnt (
        .clk(clk), .rst_n(rst_n), .arm(wake_arm), .step(smp_valid),
        .hit(over_wake), .limit(wake_len), .fire(wake_fire));
    mws_debounce #(.CW(CW)) u_sleep_cnt (
        .clk(clk), .rst_n(rst_n), .arm(sleep_arm), .step(smp_valid),
        .hit(~over_sleep), .limit(sleep_len), .fire(sleep_fire));

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_SLEEP: if (wake_fire)                  state_nxt = ST_AWAKE;
            ST_AWAKE: if (force_sleep || sleep_fire)  state_nxt = ST_SLEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SLEEP;
        else        state <= state_nxt;
    end

    always_comb begin
        awake = (state == ST_AWAKE);
    end

    mws_status u_status (
        .clk(clk), .rst_n(rst_n), .set_wake(wake_fire), .set_sleep(sleep_fire),
        .release_i(irq_release), .act_high(irq_act_high),
        .wake_flag(wake_evt), .sleep_flag(sleep_evt), .irq_pin(irq_pin));

    assert_wake_needs_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(awake) |-> $past(smp_valid && wake_en && !force_sleep));
    assert_sleep_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(awake) |-> $past(force_sleep || (smp_valid && sleep_en)));
    assert_force_sleeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        force_sleep |=> !awake);
    assert_force_no_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (force_sleep && !wake_evt && !sleep_evt) |=> (!wake_evt && !sleep_evt));
endmodule

// File: tb/sim_motion_wake_sleep.sv
module sim_motion_wake_sleep;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vld = 1'b0;
    logic signed [15:0] sx = '0, sy = '0, sz = '0;
    logic wen, sen, pol, frc = 1'b0, rel = 1'b0;
    logic [5:0]  msk;
    logic [15:0] wthr, sthr;
    logic [7:0]  wlen, slen;
    logic awake, wflag, sflag, irq;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    motion_wake_sleep #(.SW(16), .CW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(vld), .smp_x(sx), .smp_y(sy), .smp_z(sz),
        .wake_en(wen), .sleep_en(sen), .dir_mask(msk), .wake_thr(wthr), .sleep_thr(sthr),
        .wake_len(wlen), .sleep_len(slen), .irq_act_high(pol), .force_sleep(frc),
        .irq_release(rel), .awake(awake), .wake_evt(wflag), .sleep_evt(sflag), .irq_pin(irq));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; vld = 1'b0; frc = 1'b0; rel = 1'b0;
        wen = 1'b1; sen = 1'b1; pol = 1'b1; msk = 6'h3F;
        wthr = 16'd100; sthr = 16'd50; wlen = 8'd3; slen = 8'd4;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(input int x, input int y, input int z);
        sx = 16'(x); sy = 16'(y); sz = 16'(z); vld = 1'b1;
        @(negedge clk);
        vld = 1'b0; frc = 1'b0; rel = 1'b0;
    endtask

    task automatic pulse_rel();
        rel = 1'b1; @(negedge clk); rel = 1'b0;
    endtask

    task automatic pulse_frc();
        frc = 1'b1; @(negedge clk); frc = 1'b0;
    endtask

    task automatic go_awake();
        repeat (3) send(200, 0, 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 awake", awake, 0);
        chk("R1 wake_evt", wflag, 0);
        chk("R1 sleep_evt", sflag, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_wake();
        do_reset();
        send(200, 0, 0); send(0, -300, 0);
        chk("R2 before length", awake, 0);
        send(0, 0, 150);
        chk("R2 awake at length", awake, 1);
        chk("R2 wake_evt", wflag, 1);
        chk("R10 irq active high", irq, 1);
        do_reset();
        repeat (4) send(100, 0, 0);
        chk("R2 equal threshold not above", awake, 0);
        do_reset();
        wlen = 8'd0;
        send(101, 0, 0);
        chk("R2 zero length acts as one", awake, 1);
    endtask

    task automatic t_reset_count();
        do_reset();
        send(200, 0, 0); send(200, 0, 0); send(50, 0, 0);
        send(200, 0, 0); send(200, 0, 0);
        chk("R3 miss restarts count", awake, 0);
        send(200, 0, 0);
        chk("R3 full run after miss", awake, 1);
        do_reset();
        send(200, 0, 0);
        repeat (5) @(negedge clk);
        send(200, 0, 0);
        repeat (3) @(negedge clk);
        chk("R3 gaps hold count", awake, 0);
        send(200, 0, 0);
        chk("R3 count survives gaps", awake, 1);
    endtask

    task automatic t_mask();
        do_reset();
        msk = 6'h01;
        repeat (3) send(-200, 0, 0);
        chk("R4 -X masked", awake, 0);
        repeat (3) send(0, 300, -300);
        chk("R4 Y and Z masked", awake, 0);
        repeat (3) send(200, 0, 0);
        chk("R4 +X enabled", awake, 1);
        do_reset();
        msk = 6'h20;
        repeat (3) send(0, 0, 200);
        chk("R4 +Z masked", awake, 0);
        repeat (3) send(0, 0, -200);
        chk("R4 -Z bit5 enabled", awake, 1);
    endtask

    task automatic t_sleep();
        do_reset();
        go_awake(); pulse_rel();
        repeat (3) send(0, 0, 0);
        send(0, 80, 0);
        repeat (3) send(10, -50, 50);
        chk("R5 above threshold restarts", awake, 1);
        send(0, 0, 0);
        chk("R5 asleep at length", awake, 0);
        chk("R5 sleep_evt", sflag, 1);
        chk("R5 wake_evt stays clear", wflag, 0);
    endtask

    task automatic t_enable();
        do_reset();
        wen = 1'b0;
        repeat (5) send(200, 0, 0);
        chk("R6 wake disabled", awake, 0);
        chk("R6 no flag when disabled", wflag, 0);
        wen = 1'b1;
        send(200, 0, 0); send(200, 0, 0);
        chk("R6 count held at zero", awake, 0);
        send(200, 0, 0);
        chk("R6 wake after enable", awake, 1);
        sen = 1'b0;
        repeat (6) send(0, 0, 0);
        chk("R6 sleep disabled", awake, 1);
    endtask

    task automatic t_force();
        do_reset();
        go_awake();
        pulse_frc();
        chk("R7 forced asleep", awake, 0);
        chk("R7 wake flag kept", wflag, 1);
        chk("R7 no sleep flag", sflag, 0);
        do_reset();
        send(200, 0, 0); send(200, 0, 0);
        frc = 1'b1;
        send(200, 0, 0);
        chk("R7 force beats wake", awake, 0);
        chk("R7 no wake flag", wflag, 0);
        send(200, 0, 0); send(200, 0, 0);
        chk("R7 count cleared by force", awake, 0);
        send(200, 0, 0);
        chk("R7 fresh run wakes", awake, 1);
    endtask

    task automatic t_latch();
        do_reset();
        go_awake();
        repeat (10) @(negedge clk);
        chk("R8 flag holds", wflag, 1);
        pulse_rel();
        chk("R8 release clears wake", wflag, 0);
        chk("R8 irq inactive", irq, 0);
    endtask

    task automatic t_collision();
        do_reset();
        go_awake();
        repeat (3) send(0, 0, 0);
        rel = 1'b1;
        send(0, 0, 0);
        chk("R9 sleep flag wins", sflag, 1);
        chk("R9 wake flag released", wflag, 0);
        chk("R9 irq stays active", irq, 1);
    endtask

    task automatic t_polarity();
        do_reset();
        pol = 1'b0;
        @(negedge clk);
        chk("R10 low idle high", irq, 1);
        go_awake();
        chk("R10 low active", irq, 0);
        pulse_rel();
        chk("R10 low released", irq, 1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        t_wake();
        t_reset_count();
        t_mask();
        t_sleep();
        t_enable();
        t_force();
        t_latch();
        t_collision();
        t_polarity();
        finish_run();
    end
endmodule